// File: doc/BRIEF.md
# Shared-Write Multi-Read Bit-Column Memory

This block is a small memory with 64 entries of 4 bits. It is kept as four separate one-bit columns, named A, B, C and D. The four columns share one clock and one write address, so a write puts a whole 4-bit word at that address in a single cycle. Each column also has its own read address, and its output bit follows that address combinationally. The column D address does two jobs: it selects the write location and it selects the read location for column D.

The integrator builds other memory shapes by tying the block's inputs together. If the A, B and C read addresses are tied, the block is a 64x3 simple dual-port memory: writes go through the D address and reads come through the shared A/B/C address. If all four addresses are tied, the block is a 64x4 single-port memory. Every entry holds zero at power-up, and the block has no reset pin.

Top module: `mcol_ram`

## Requirements
- R1: At power-up every one of the 64 entries reads as zero in all four columns.
- R2: On a rising edge of `wr_clk` with `wr_en` high, each column stores its own write-data bit at `addr_d`: `din[0]` goes to A, `din[1]` to B, `din[2]` to C and `din[3]` to D.
- R3: On a rising edge with `wr_en` low, nothing is stored, whatever `din` and `addr_d` hold.
- R4: `dout[0]` is column A at `addr_a`, `dout[1]` is column B at `addr_b` and `dout[2]` is column C at `addr_c`. Each bit follows its address combinationally, with no clock.
- R5: `dout[3]` is column D at `addr_d`, so column D works as a combined read/write port.
- R6: If a read address equals `addr_d` while a write is pending, that output shows the old bit until the rising edge and the new bit straight after it.
- R7: With `addr_a`, `addr_b` and `addr_c` driven equal, `dout[2:0]` returns the 3-bit word last written at that address through `addr_d`.
- R8: With all four addresses driven equal, `dout` returns the full 4-bit word last written at that address.
- R9: A write changes only the addressed entry. Every other entry keeps its contents in all columns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write clock; storage updates on the rising edge |
| wr_en | input | 1 | Active-high write enable |
| addr_d | input | 6 | Write address for all columns and read address for column D |
| addr_a | input | 6 | Read address for column A |
| addr_b | input | 6 | Read address for column B |
| addr_c | input | 6 | Read address for column C |
| din | input | 4 | Write data, one bit per column (bit 0 = A ... bit 3 = D) |
| dout | output | 4 | Read data, one bit per column (bit 0 = A ... bit 3 = D) |

## Verification
The assertions assume that the enable and all four addresses are known at every rising edge, and that they change only between edges. Under that assumption, a stable address across a clock means the same entry was read both times. The bench drives every input on the falling edge and compares the outputs a short time later, on both sides of each rising edge. As a result, no input ever moves at the edge where a write or a property is sampled.

// File: rtl/mcol_pkg.sv
package mcol_pkg;
    parameter int MC_DEPTH = 64;
    parameter int MC_COLS  = 4;
    localparam int MC_AW   = $clog2(MC_DEPTH);

    typedef logic [MC_AW-1:0] mc_addr_t;
endpackage

// File: rtl/mcol_wdec.sv
// Turns the shared write address and enable into one-hot row strobes.
module mcol_wdec #(
    parameter int DEPTH = mcol_pkg::MC_DEPTH,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    output logic [DEPTH-1:0] row_we
);
    for (genvar r = 0; r < DEPTH; r++) begin : g_row
        assign row_we[r] = wr_en && (wr_addr == AW'(r));
    end
endmodule

// File: rtl/mcol_column.sv
// One 1-bit column: a write through the row strobes, and an asynchronous read mux.
module mcol_column #(
    parameter int DEPTH = mcol_pkg::MC_DEPTH,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic [DEPTH-1:0] row_we,
    input  logic             wr_bit,
    input  logic [AW-1:0]    rd_addr,
    output logic             rd_bit
);
    typedef struct packed {
        logic [DEPTH-1:0] cells;
    } col_state_t;

    col_state_t st_d;
    col_state_t st_q = '0;

    always_comb begin
        st_d = st_q;
        for (int r = 0; r < DEPTH; r++) begin
            if (row_we[r]) begin
                st_d.cells[r] = wr_bit;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rd_bit = st_q.cells[rd_addr];
endmodule

// File: rtl/mcol_ram.sv
module mcol_ram #(
    parameter int DEPTH = mcol_pkg::MC_DEPTH,
    localparam int AW   = $clog2(DEPTH),
    localparam int NCOL = mcol_pkg::MC_COLS
) (
    input  logic            wr_clk,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr_d,
    input  logic [AW-1:0]   addr_a,
    input  logic [AW-1:0]   addr_b,
    input  logic [AW-1:0]   addr_c,
    input  logic [NCOL-1:0] din,
    output logic [NCOL-1:0] dout
);
    logic [DEPTH-1:0] row_we;
    logic [AW-1:0]    col_raddr [NCOL];

    // Column order is fixed: A, B, C read on their own addresses; D reads on the write address.
    assign col_raddr[0] = addr_a;
    assign col_raddr[1] = addr_b;
    assign col_raddr[2] = addr_c;
    assign col_raddr[3] = addr_d;

    mcol_wdec #(.DEPTH(DEPTH)) u_wdec (
        .wr_en   (wr_en),
        .wr_addr (addr_d),
        .row_we  (row_we)
    );

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        mcol_column #(.DEPTH(DEPTH)) u_col (
            .clk     (wr_clk),
            .row_we  (row_we),
            .wr_bit  (din[c]),
            .rd_addr (col_raddr[c]),
            .rd_bit  (dout[c])
        );
    end
endmodule

// File: rtl/mcol_ram_chk.sv
module mcol_ram_chk #(
    parameter int AW = 6
) (
    input logic          wr_clk,
    input logic          wr_en,
    input logic [AW-1:0] addr_d,
    input logic [AW-1:0] addr_a,
    input logic [AW-1:0] addr_b,
    input logic [AW-1:0] addr_c,
    input logic [3:0]    din,
    input logic [3:0]    dout
);
    // No reset pin: properties start after the first clock edge.
    logic primed = 1'b0;
    always_ff @(posedge wr_clk) primed <= 1'b1;

    always_comb begin
        if (primed) begin
            a_known_r1: assert (!$isunknown(dout));
        end
    end

    p_wr_thru_a_r2: assert property (@(posedge wr_clk) disable iff (!primed)
        (wr_en && addr_a == addr_d) |=>
        (($stable(addr_a) && $stable(addr_d)) |-> dout[0] == $past(din[0])));

    p_wr_thru_b_r4: assert property (@(posedge wr_clk) disable iff (!primed)
        (wr_en && addr_b == addr_d) |=>
        (($stable(addr_b) && $stable(addr_d)) |-> dout[1] == $past(din[1])));

    p_wr_thru_c_r7: assert property (@(posedge wr_clk) disable iff (!primed)
        (wr_en && addr_c == addr_d) |=>
        (($stable(addr_c) && $stable(addr_d)) |-> dout[2] == $past(din[2])));

    p_wr_thru_d_r6: assert property (@(posedge wr_clk) disable iff (!primed)
        wr_en |=> ($stable(addr_d) |-> dout[3] == $past(din[3])));

    p_hold_r3: assert property (@(posedge wr_clk) disable iff (!primed)
        !wr_en |=>
        (($stable(addr_a) && $stable(addr_b) && $stable(addr_c) && $stable(addr_d))
         |-> $stable(dout)));
endmodule

bind mcol_ram mcol_ram_chk #(.AW(AW)) u_mcol_ram_chk (
    .wr_clk (wr_clk),
    .wr_en  (wr_en),
    .addr_d (addr_d),
    .addr_a (addr_a),
    .addr_b (addr_b),
    .addr_c (addr_c),
    .din    (din),
    .dout   (dout)
);

// File: tb/mcol_ram_bench.sv
module mcol_ram_bench;
    logic       wr_clk = 1'b0;
    logic       wr_en  = 1'b0;
    logic [5:0] addr_d = '0, addr_a = '0, addr_b = '0, addr_c = '0;
    logic [3:0] din    = '0;
    logic [3:0] dout;

    int errors = 0;
    int checks = 0;
    logic [3:0] model [64];

    always #2 wr_clk = ~wr_clk;   // 250 MHz

    mcol_ram u_mcol_ram (
        .wr_clk (wr_clk), .wr_en (wr_en), .addr_d (addr_d),
        .addr_a (addr_a), .addr_b (addr_b), .addr_c (addr_c),
        .din (din), .dout (dout)
    );

    // {we, waddr, din, ra, rb, rc}
    localparam logic [28:0] VECS [0:15] = '{
        {1'b1, 6'd5,  4'hA, 6'd5,  6'd5,  6'd5 },
        {1'b1, 6'd6,  4'h5, 6'd5,  6'd6,  6'd0 },
        {1'b1, 6'd63, 4'hF, 6'd6,  6'd5,  6'd63},
        {1'b1, 6'd0,  4'h9, 6'd63, 6'd0,  6'd6 },
        {1'b0, 6'd5,  4'h0, 6'd5,  6'd63, 6'd0 },
        {1'b1, 6'd5,  4'h3, 6'd0,  6'd5,  6'd5 },
        {1'b1, 6'd40, 4'hC, 6'd5,  6'd40, 6'd63},
        {1'b0, 6'd40, 4'h0, 6'd40, 6'd40, 6'd40},
        {1'b1, 6'd1,  4'h1, 6'd1,  6'd2,  6'd3 },
        {1'b1, 6'd2,  4'h2, 6'd1,  6'd2,  6'd3 },
        {1'b1, 6'd3,  4'h4, 6'd1,  6'd2,  6'd3 },
        {1'b1, 6'd4,  4'h8, 6'd4,  6'd3,  6'd2 },
        {1'b0, 6'd4,  4'hF, 6'd1,  6'd2,  6'd4 },
        {1'b1, 6'd63, 4'h0, 6'd63, 6'd0,  6'd40},
        {1'b1, 6'd32, 4'h6, 6'd31, 6'd32, 6'd33},
        {1'b0, 6'd0,  4'h0, 6'd32, 6'd32, 6'd0 }
    };

    task automatic check_out(input string tag);
        logic [3:0] exp;
        exp[0] = model[addr_a][0];
        exp[1] = model[addr_b][1];
        exp[2] = model[addr_c][2];
        exp[3] = model[addr_d][3];
        checks++;
        if (dout !== exp) begin
            errors++;
            $display("FAIL %s: dout=%h expected=%h (wa=%0d ra=%0d rb=%0d rc=%0d)",
                     tag, dout, exp, addr_d, addr_a, addr_b, addr_c);
        end
    endtask

    // Drive on the falling edge, check before the rising edge (old data)
    // and again after it (new data).
    task automatic apply(input logic we, input logic [5:0] wa, input logic [3:0] d,
                         input logic [5:0] ra, input logic [5:0] rb, input logic [5:0] rc,
                         input string tag);
        @(negedge wr_clk);
        wr_en = we; addr_d = wa; din = d; addr_a = ra; addr_b = rb; addr_c = rc;
        #1 check_out({tag, " pre-edge"});
        @(posedge wr_clk);
        if (we) model[wa] = d;
        #1 check_out({tag, " post-edge"});
    endtask

    initial begin
        for (int i = 0; i < 64; i++) model[i] = 4'h0;

        // R1: every entry reads zero at power-up
        for (int i = 0; i < 64; i++) begin
            #1;
            addr_a = 6'(i); addr_b = 6'(i); addr_c = 6'(i); addr_d = 6'(i);
            #1 check_out("R1 power-up zero");
        end

        // Vector table: R2 R4 R5 R9
        for (int v = 0; v < 16; v++) begin
            apply(VECS[v][28], VECS[v][27:22], VECS[v][21:18],
                  VECS[v][17:12], VECS[v][11:6], VECS[v][5:0], "R2 R4 R5 R9 vector");
        end

        // R3: disabled write with all-ones data leaves entry 10 at zero
        apply(1'b0, 6'd10, 4'hF, 6'd10, 6'd10, 6'd10, "R3 hold");
        apply(1'b0, 6'd11, 4'hF, 6'd10, 6'd10, 6'd10, "R3 hold readback");

        // R6: rewrite entry 20, old value visible before the edge, new after
        apply(1'b1, 6'd20, 4'h5, 6'd20, 6'd20, 6'd20, "R6 first write");
        apply(1'b1, 6'd20, 4'hA, 6'd20, 6'd20, 6'd20, "R6 overwrite");

        // R7: A/B/C tied as a 3-bit read port, writes elsewhere through D
        apply(1'b1, 6'd50, 4'h7, 6'd20, 6'd20, 6'd20, "R7 write");
        apply(1'b1, 6'd51, 4'h2, 6'd50, 6'd50, 6'd50, "R7 read back");

        // R8: all four addresses tied
        apply(1'b1, 6'd33, 4'hD, 6'd33, 6'd33, 6'd33, "R8 single-port write");
        apply(1'b0, 6'd33, 4'h0, 6'd33, 6'd33, 6'd33, "R8 single-port read");

        // Random writes and independent reads: R4 R9
        for (int n = 0; n < 400; n++) begin
            apply(1'($urandom), 6'($urandom), 4'($urandom), 6'($urandom),
                  6'($urandom), 6'($urandom), "R4 R9 random");
        end

        // R9: sweep all entries against the model
        for (int i = 0; i < 64; i++) begin
            apply(1'b0, 6'(i), 4'h0, 6'(i), 6'(i), 6'(i), "R9 final sweep");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge wr_clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not end, actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule